// File: doc/BRIEF.md
# FIFO Status and Interrupt Register Block

This block is the register slice of a digital I/O port that moves data through an input FIFO and an output FIFO. It keeps two sticky error flags. One records a word that arrived while the input FIFO was full. The other records a word that was requested while the output FIFO was empty. It also holds one bit that drives the output trigger pin. It reads back the live FIFO empty and full flags, and it can emit a one-cycle reset pulse to both FIFOs.

Five interrupt sources report to it: output acknowledge, input request and three timer events. Each source has an enable bit and a latched status bit. The status bit is set on the source's edge, whether or not the source is enabled. The single interrupt line is the OR of every status bit whose enable bit is also set. Software clears a status bit by writing 1 to it.

The host reaches the registers through a byte-addressed port. A write is a one-cycle strobe. A read returns data combinationally from the addressed byte. Address 0 is the flag and trigger byte. Addresses 4 to 7 are the four bytes of the interrupt register. The timers, the FIFOs and the bus bridge are outside the block.

Top module: `fsr_top`

## Requirements
- R1: After reset, every address reads 0 (apart from the live FIFO flag bits), and `trig_o`, `fifo_rst_o`, `chain_o` and `irq_o` are all 0.
- R2: Bit 0 of address 0 is a read/write bit that drives `trig_o`: 1 drives the pin high and 0 drives it low.
- R3: Bit 1 of address 0 (input overrun) becomes 1 at any clock edge where `in_full_i` and `in_push_i` are both 1. Writing 1 to this bit clears it. Writing 0 leaves it unchanged.
- R4: Bit 2 of address 0 (output underrun) becomes 1 at any clock edge where `out_empty_i` and `out_pop_i` are both 1. It is cleared by a write of 1 only.
- R5: Address 4, bits 0 to 4, hold the enables for output-ack, input-request, timer 0, timer 1 and timer 2, in that order. These bits are read/write.
- R6: The status bits sit at address 4 bits 5, 6 and 7 (output-ack, input-request, timer 0) and at address 5 bits 0 and 1 (timer 1, timer 2). A status bit is set on its source's edge (rising, unless R8 selects otherwise), whatever its enable. A write of 1 clears it, and a write of 0 leaves it unchanged.
- R7: `irq_o` is 1 exactly when some status bit and its enable bit are both 1. A pending status bit raises `irq_o` as soon as its enable is written to 1.
- R8: Address 5 bit 4 selects the edge for the input-request source: 0 selects the rising edge and 1 selects the falling edge.
- R9: Address 5 bit 2 (timer 0/timer 2 chaining) and bit 3 (timer 1/timer 2 chaining) are read/write bits that drive `chain_o[0]` and `chain_o[1]`.
- R10: Writing 1 to address 5 bit 5 makes `fifo_rst_o` high for exactly the one cycle after the write. This bit always reads 0.
- R11: Address 5 bit 6 reads the live `out_empty_i` and bit 7 reads the live `in_full_i`. Writes to these bits have no effect.
- R12: If a set event and a write-1 clear hit the same flag or status bit in the same cycle, the bit ends up set.
- R13: Addresses 1, 2, 3, 6 and 7 read 0, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per byte write |
| bus_addr | input | 3 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed byte (combinational) |
| in_full_i | input | 1 | Input FIFO is full |
| in_push_i | input | 1 | A new input word arrives this cycle |
| out_empty_i | input | 1 | Output FIFO is empty |
| out_pop_i | input | 1 | Output side requests a word this cycle |
| oack_i | input | 1 | Output-acknowledge source level |
| ireq_i | input | 1 | Input-request source level |
| tmr_i | input | 3 | Timer 0..2 event levels |
| trig_o | output | 1 | Output trigger pin drive |
| fifo_rst_o | output | 1 | One-cycle reset pulse to both FIFOs |
| chain_o | output | 2 | Timer chaining selects (bit0 t0/t2, bit1 t1/t2) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two things can reach the same status bit in one cycle: a source edge that sets the bit and a host write of 1 that clears it. The overrun and underrun flags face the same collision from a push or pop against a full or empty FIFO. The bench provokes each collision by raising the source, or the push or pop condition, on the same negative edge that starts the clearing write. Both then land on the same rising edge. The bench judges the outcome by reading the bit back afterwards and requires it to be set. A separate write-1 with no event must then clear it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int NTMR   = 3;
    localparam int NSRC   = 2 + NTMR;

    // source index within enable/status vectors
    localparam int SRC_OACK = 0;
    localparam int SRC_IREQ = 1;
    localparam int SRC_T0   = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_IRQ0 = 3'd4;
    localparam logic [ADDR_W-1:0] A_IRQ1 = 3'd5;

    typedef struct packed {
        logic trig;
        logic ovr;
        logic und;
    } flag_t;

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] stat;
        logic            t0_chain;
        logic            t1_chain;
        logic            req_fall;
        logic            fifo_rst;
    } irq_regs_t;
endpackage

// File: rtl/fsr_edge_det.sv
module fsr_edge_det #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] fall_sel,
    output logic [N-1:0] evt
);
    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        logic rise, fall;
        assign rise   = raw[i] & ~prev_q[i];
        assign fall   = ~raw[i] & prev_q[i];
        assign evt[i] = fall_sel[i] ? fall : rise;
    end

    // R8
    evt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt & ~(raw ^ prev_q)) == '0));
endmodule

// File: rtl/fsr_fifo_flags.sv
module fsr_fifo_flags
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [2:0] wbits,
    input  logic       in_full,
    input  logic       in_push,
    input  logic       out_empty,
    input  logic       out_pop,
    output flag_t      flags
);
    flag_t f_d, f_q;
    logic  ovr_evt, und_evt;

    assign ovr_evt = in_full & in_push;
    assign und_evt = out_empty & out_pop;

    always_comb begin
        f_d = f_q;
        if (wr_ctrl) begin
            f_d.trig = wbits[0];
            if (wbits[1]) f_d.ovr = 1'b0;
            if (wbits[2]) f_d.und = 1'b0;
        end
        if (ovr_evt) f_d.ovr = 1'b1;
        if (und_evt) f_d.und = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;

    // R3
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_full && in_push) |-> flags.ovr);
    // R4
    und_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(out_empty && out_pop) |-> flags.und);
    // R3
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flags.ovr) && !($past(wr_ctrl) && $past(wbits[1]))) |-> flags.ovr);
    // R2
    trig_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_ctrl) |-> (flags.trig == $past(wbits[0])));
endmodule

// File: rtl/fsr_irq_core.sv
module fsr_irq_core
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_b0,
    input  logic              wr_b1,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NSRC-1:0]   evt,
    output irq_regs_t         regs,
    output logic              irq_o
);
    irq_regs_t     r_d, r_q;
    logic [NSRC-1:0] clr;
    logic            unused_hi;

    assign unused_hi = ^wdata[7:6];

    // W1C masks: byte0 bits 5..7 -> sources 0..2, byte1 bits 0..1 -> timers 1,2
    always_comb begin
        clr = '0;
        for (int i = 0; i < 3; i++) clr[i] = wr_b0 & wdata[5+i];
        for (int i = 3; i < NSRC; i++) clr[i] = wr_b1 & wdata[i-3];
    end

    always_comb begin
        r_d = r_q;
        r_d.fifo_rst = 1'b0;
        if (wr_b0) r_d.en = wdata[NSRC-1:0];
        if (wr_b1) begin
            r_d.t0_chain = wdata[2];
            r_d.t1_chain = wdata[3];
            r_d.req_fall = wdata[4];
            r_d.fifo_rst = wdata[5];
        end
        r_d.stat = (r_q.stat & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign regs  = r_q;
    assign irq_o = |(r_q.stat & r_q.en);

    // R6
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(r_q.stat) & ~$past(clr)) & ~r_q.stat) == '0));
    // R12
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(evt) & ~r_q.stat) == '0));
    // R10
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fifo_rst |-> ($past(wr_b1) && $past(wdata[5])));
    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_o) && !$past(wr_b0) && !$past(wr_b1)) |-> irq_o);
endmodule

// File: rtl/fsr_top.sv
module fsr_top
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              in_full_i,
    input  logic              in_push_i,
    input  logic              out_empty_i,
    input  logic              out_pop_i,
    input  logic              oack_i,
    input  logic              ireq_i,
    input  logic [NTMR-1:0]   tmr_i,
    output logic              trig_o,
    output logic              fifo_rst_o,
    output logic [1:0]        chain_o,
    output logic              irq_o
);
    logic            wr_ctrl, wr_b0, wr_b1;
    logic [NSRC-1:0] raw, fall_sel, evt;
    flag_t           flags;
    irq_regs_t       regs;

    assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
    assign wr_b0   = bus_we && (bus_addr == A_IRQ0);
    assign wr_b1   = bus_we && (bus_addr == A_IRQ1);

    assign raw = {tmr_i, ireq_i, oack_i};

    always_comb begin
        fall_sel = '0;
        fall_sel[SRC_IREQ] = regs.req_fall;
    end

    fsr_edge_det #(.N(NSRC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (raw),
        .fall_sel (fall_sel),
        .evt      (evt)
    );

    fsr_fifo_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wbits     (bus_wdata[2:0]),
        .in_full   (in_full_i),
        .in_push   (in_push_i),
        .out_empty (out_empty_i),
        .out_pop   (out_pop_i),
        .flags     (flags)
    );

    fsr_irq_core u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_b0 (wr_b0),
        .wr_b1 (wr_b1),
        .wdata (bus_wdata),
        .evt   (evt),
        .regs  (regs),
        .irq_o (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: bus_rdata = {5'b0, flags.und, flags.ovr, flags.trig};
            A_IRQ0: bus_rdata = {regs.stat[SRC_T0:0], regs.en};
            A_IRQ1: bus_rdata = {in_full_i, out_empty_i, 1'b0, regs.req_fall,
                                 regs.t1_chain, regs.t0_chain,
                                 regs.stat[NSRC-1:SRC_T0+1]};
            default: bus_rdata = '0;
        endcase
    end

    assign trig_o     = flags.trig;
    assign fifo_rst_o = regs.fifo_rst;
    assign chain_o    = {regs.t1_chain, regs.t0_chain};

    // R13
    rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr != A_CTRL && bus_addr != A_IRQ0 && bus_addr != A_IRQ1)
        |-> (bus_rdata == '0));
    // R9
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_b1) |-> $stable(chain_o));
endmodule

// File: tb/tb_fsr_top.sv
module tb_fsr_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       in_full_i = 0, in_push_i = 0, out_empty_i = 0, out_pop_i = 0;
    logic [4:0] src = '0;
    logic       trig_o, fifo_rst_o, irq_o;
    logic [1:0] chain_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fsr_top dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_full_i(in_full_i), .in_push_i(in_push_i),
        .out_empty_i(out_empty_i), .out_pop_i(out_pop_i),
        .oack_i(src[0]), .ireq_i(src[1]), .tmr_i(src[4:2]),
        .trig_o(trig_o), .fifo_rst_o(fifo_rst_o), .chain_o(chain_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input int s);
        @(negedge clk); src[s] = 1'b1;
        @(negedge clk); src[s] = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d);
            chk("R1 read", d, 0);
        end
        chk("R1 outs", {trig_o, fifo_rst_o, chain_o, irq_o}, 0);

        // R5 R6 R7 sweep over enable masks and sources
        for (int m = 0; m < 32; m++) begin
            for (int s = 0; s < 5; s++) begin
                wr(3'd4, m[7:0]);
                pulse(s);
                rd(3'd4, d);
                chk("R5/R6 byte0", d, m[7:0] | ((s < 3) ? (8'd1 << (5 + s)) : 8'd0));
                rd(3'd5, d);
                chk("R6 byte1", d, (s >= 3) ? (8'd1 << (s - 3)) : 8'd0);
                chk("R7 irq", irq_o, m[s]);
                if (s < 3) wr(3'd4, m[7:0] | (8'd1 << (5 + s)));
                else       wr(3'd5, 8'd1 << (s - 3));
                rd(3'd4, d);
                chk("R6 cleared", d, m[7:0]);
                chk("R7 irq low", irq_o, 0);
            end
        end

        // R6 write 0 leaves status; R7 late enable
        wr(3'd4, 8'h00);
        pulse(3);
        chk("R7 disabled", irq_o, 0);
        wr(3'd5, 8'h00);
        rd(3'd5, d);
        chk("R6 write0 keeps", d, 8'h01);
        wr(3'd4, 8'h08);
        chk("R7 late enable", irq_o, 1);
        wr(3'd5, 8'h01);
        chk("R7 cleared", irq_o, 0);

        // R8 falling-edge input request
        wr(3'd5, 8'h10);
        @(negedge clk); src[1] = 1'b1;
        @(negedge clk);
        rd(3'd4, d);
        chk("R8 no rise evt", d[6], 0);
        src[1] = 1'b0;
        @(negedge clk);
        rd(3'd4, d);
        chk("R8 fall evt", d[6], 1);
        wr(3'd4, 8'h48);
        wr(3'd5, 8'h00);
        pulse(1);
        rd(3'd4, d);
        chk("R8 rise evt", d[6], 1);
        wr(3'd4, 8'h40);

        // R3 R4 sweep
        for (int c = 0; c < 4; c++) begin
            wr(3'd0, 8'h06);
            @(negedge clk);
            in_full_i = c[0]; in_push_i = c[1];
            out_empty_i = c[0]; out_pop_i = c[1];
            @(negedge clk);
            in_full_i = 0; in_push_i = 0; out_empty_i = 0; out_pop_i = 0;
            rd(3'd0, d);
            chk("R3 ovr", d[1], c[0] & c[1]);
            chk("R4 und", d[2], c[0] & c[1]);
        end
        wr(3'd0, 8'h00);
        rd(3'd0, d);
        chk("R3/R4 write0 keeps", d, 8'h06);
        wr(3'd0, 8'h06);
        rd(3'd0, d);
        chk("R3/R4 w1c", d, 8'h00);

        // R12 same-cycle set and clear
        @(negedge clk);
        in_full_i = 1; in_push_i = 1; out_empty_i = 1; out_pop_i = 1;
        bus_addr = 3'd0; bus_wdata = 8'h06; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 0; in_full_i = 0; in_push_i = 0; out_empty_i = 0; out_pop_i = 0;
        rd(3'd0, d);
        chk("R12 flags", d, 8'h06);
        wr(3'd0, 8'h06);
        pulse(2);
        @(negedge clk);
        src[2] = 1'b1;
        bus_addr = 3'd4; bus_wdata = 8'h80; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 0; src[2] = 1'b0;
        rd(3'd4, d);
        chk("R12 status", d[7], 1);
        wr(3'd4, 8'h80);
        rd(3'd4, d);
        chk("R12 then clear", d, 8'h00);

        // R2 trigger
        wr(3'd0, 8'h01);
        rd(3'd0, d);
        chk("R2 high", {trig_o, d}, 9'h101);
        wr(3'd0, 8'h00);
        chk("R2 low", trig_o, 0);

        // R9 chaining
        wr(3'd5, 8'h0C);
        chk("R9 both", chain_o, 2'b11);
        wr(3'd5, 8'h04);
        rd(3'd5, d);
        chk("R9 t0 only", {chain_o, d}, {2'b01, 8'h04});

        // R10 FIFO reset pulse
        @(negedge clk);
        bus_addr = 3'd5; bus_wdata = 8'h20; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 0;
        chk("R10 pulse", fifo_rst_o, 1);
        rd(3'd5, d);
        chk("R10 reads 0", d, 8'h00);
        @(negedge clk);
        chk("R10 one cycle", fifo_rst_o, 0);

        // R11 live FIFO flags
        for (int c = 0; c < 4; c++) begin
            out_empty_i = c[0]; in_full_i = c[1];
            wr(3'd5, 8'hC0);
            rd(3'd5, d);
            chk("R11 flags", d, {c[1], c[0], 6'b0});
        end
        out_empty_i = 0; in_full_i = 0;

        // R13 reserved addresses
        wr(3'd4, 8'h15);
        wr(3'd0, 8'h01);
        for (int a = 1; a < 8; a++) begin
            if (a == 4 || a == 5) continue;
            wr(a[2:0], 8'hFF);
            rd(a[2:0], d);
            chk("R13 reads 0", d, 0);
        end
        rd(3'd4, d);
        chk("R13 en kept", d, 8'h15);
        rd(3'd5, d);
        chk("R13 cfg kept", d, 8'h00);
        rd(3'd0, d);
        chk("R13 ctrl kept", {d, fifo_rst_o, irq_o}, {8'h01, 2'b00});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule